// File: doc/BRIEF.md
# Power-Mode-Aware Watchdog Timer

This block is a watchdog built from two stages. A base counter advances once for each pulse on a slow tick input. Each time it wraps, it advances a postscaler whose terminal count is chosen by a 4-bit exponent. When the last tick of a period arrives, the block looks at the core's execution state. If the core is running code, it issues a one-cycle reset request. If the core is idle or asleep, it issues a one-cycle wake request instead.

Both stages restart from zero when any qualified clear event occurs:
- a clear-watchdog strobe;
- a sleep strobe;
- a loss of the selected clock, but only while the fail-safe monitor is enabled;
- a write to the clock-frequency field, but only while the internal oscillator drives the system.

Clear events that arrive in the same cycle merge into one clear. The block also drives the enable for the slow oscillator, which must run whenever the watchdog or the fail-safe monitor needs it.

Top module: `pm_watchdog`

## Requirements
- R1: When `core_run_i`=1 in the cycle that completes a period, `wdt_rst_o` pulses high for one cycle after that edge, and `wake_req_o` stays low.
- R2: When `core_run_i`=0 in the cycle that completes a period, `wake_req_o` pulses high for one cycle after that edge, and `wdt_rst_o` stays low.
- R3: Each request pulse lasts exactly one cycle. After a time-out, counting restarts from zero, so the next time-out needs a full period again.
- R4: A high `sleep_i` clears both counter stages.
- R5: A high `kick_i` clears both counter stages.
- R6: `clk_lost_i` clears both stages only when `fscm_en_i`=1. With `fscm_en_i`=0 it has no effect.
- R7: `freq_wr_i` clears both stages only when `int_osc_sel_i`=1. With `int_osc_sel_i`=0 it has no effect.
- R8: A clear wins over a tick in the same cycle. Several clear sources in one cycle act as a single clear.
- R9: While `wdt_en_i`=0, both stages hold at zero and neither request output is asserted. After re-enable, a full period is needed.
- R10: `lfosc_en_o` equals `wdt_en_i` OR `fscm_en_i`.
- R11: A period is 2^(BASE_W + `ps_sel_i`) ticks, where `ps_sel_i` is an unsigned exponent from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per low-frequency period |
| wdt_en_i | input | 1 | Watchdog enable |
| core_run_i | input | 1 | 1 = core executing, 0 = idle or sleep |
| kick_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Sleep-entry strobe |
| clk_lost_i | input | 1 | Selected clock failure indication |
| fscm_en_i | input | 1 | Fail-safe clock monitor enable |
| freq_wr_i | input | 1 | Write strobe to the clock frequency field |
| int_osc_sel_i | input | 1 | Internal oscillator is the system clock |
| ps_sel_i | input | 4 | Postscaler exponent n |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |
| wake_req_o | output | 1 | One-cycle wake request |
| lfosc_en_o | output | 1 | Low-frequency oscillator enable |

## Verification
A counter stage that keeps a stale value after a clear shows up at the ports as a time-out that comes early. Counting from the clear, this is short of the full 2^(BASE_W+n) ticks, and it becomes visible in the first period after the clear. A mis-routed mode shows up at once as the wrong request pin on the very time-out edge. A stuck pulse register shows up one cycle later as a request held for two cycles. The tests count ticks exactly, so an off-by-one in the terminal compare or the postscaler mask moves the pulse by at least one tick edge.

// File: rtl/pm_wdt_pkg.sv
package pm_wdt_pkg;
  typedef struct packed {
    logic sleep;
    logic kick;
    logic clk_loss;
    logic freq_wr;
  } clr_src_t;

  localparam int unsigned CLR_SRC_N = $bits(clr_src_t);
endpackage

// File: rtl/pm_wdt_clr_merge.sv
module pm_wdt_clr_merge
  import pm_wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic kick_i,
  input  logic clk_lost_i,
  input  logic fscm_en_i,
  input  logic freq_wr_i,
  input  logic int_osc_sel_i,
  output logic clr_o
);
  clr_src_t src;

  always_comb begin
    src.sleep    = sleep_i;
    src.kick     = kick_i;
    src.clk_loss = clk_lost_i & fscm_en_i;
    src.freq_wr  = freq_wr_i & int_osc_sel_i;
    clr_o        = |src;
  end

  // R6 / R7: an unqualified event never produces a clear on its own
  a_r6_loss_needs_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_lost_i && !fscm_en_i && !sleep_i && !kick_i && !(freq_wr_i && int_osc_sel_i)) |-> !clr_o);
  a_r7_freq_needs_intosc: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_wr_i && !int_osc_sel_i && !sleep_i && !kick_i && !(clk_lost_i && fscm_en_i)) |-> !clr_o);
endmodule

// File: rtl/pm_wdt_base_ctr.sv
module pm_wdt_base_ctr #(
  parameter int unsigned BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              tick_i,
  output logic [BASE_W-1:0] cnt_o,
  output logic              carry_o
);
  localparam logic [BASE_W-1:0] CNT_MAX = {BASE_W{1'b1}};

  logic [BASE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign carry_o = tick_i & ~clr_i & (cnt_q == CNT_MAX);
  assign cnt_o   = cnt_q;

  // R8: a clear always lands the stage on zero
  a_r8_base_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/pm_wdt_postscaler.sv
module pm_wdt_postscaler #(
  parameter int unsigned SEL_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     inc_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [(1<<SEL_W)-2:0]    cnt_o,
  output logic                     term_o
);
  localparam int unsigned PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  always_comb begin
    mask = (PS_W'(1) << sel_i) - PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign term_o = (cnt_q == mask);
  assign cnt_o  = cnt_q;

  // R8: a clear always lands the postscaler on zero
  a_r8_post_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/pm_watchdog.sv
module pm_watchdog #(
  parameter int unsigned BASE_W = 8,
  parameter int unsigned SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wdt_en_i,
  input  logic             core_run_i,
  input  logic             kick_i,
  input  logic             sleep_i,
  input  logic             clk_lost_i,
  input  logic             fscm_en_i,
  input  logic             freq_wr_i,
  input  logic             int_osc_sel_i,
  input  logic [SEL_W-1:0] ps_sel_i,
  output logic             wdt_rst_o,
  output logic             wake_req_o,
  output logic             lfosc_en_o
);
  localparam int unsigned PS_W = (1 << SEL_W) - 1;

  logic              evt_clr;
  logic              stage_clr;
  logic              tick_ok;
  logic              carry;
  logic              term;
  logic              timeout;
  logic [BASE_W-1:0] base_cnt;
  logic [PS_W-1:0]   post_cnt;
  logic              rst_q;
  logic              wake_q;

  pm_wdt_clr_merge u_clr (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_i       (sleep_i),
    .kick_i        (kick_i),
    .clk_lost_i    (clk_lost_i),
    .fscm_en_i     (fscm_en_i),
    .freq_wr_i     (freq_wr_i),
    .int_osc_sel_i (int_osc_sel_i),
    .clr_o         (evt_clr)
  );

  assign tick_ok   = tick_i & wdt_en_i;
  assign timeout   = carry & term & wdt_en_i;
  assign stage_clr = evt_clr | ~wdt_en_i | timeout;

  pm_wdt_base_ctr #(.BASE_W(BASE_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (evt_clr | ~wdt_en_i),
    .tick_i  (tick_ok),
    .cnt_o   (base_cnt),
    .carry_o (carry)
  );

  pm_wdt_postscaler #(.SEL_W(SEL_W)) u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (stage_clr),
    .inc_i  (carry),
    .sel_i  (ps_sel_i),
    .cnt_o  (post_cnt),
    .term_o (term)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      rst_q  <= timeout & core_run_i;
      wake_q <= timeout & ~core_run_i;
    end
  end

  assign wdt_rst_o  = rst_q;
  assign wake_req_o = wake_q;
  assign lfosc_en_o = wdt_en_i | fscm_en_i;

  // R1 / R2: request kind follows the mode seen on the time-out edge
  a_r1_reset_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> $past(core_run_i));
  a_r2_wake_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> !$past(core_run_i));
  a_r2_one_request_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_rst_o && wake_req_o));
  // R3: single-cycle pulses, and counting restarts at zero
  a_r3_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> !wdt_rst_o);
  a_r3_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |=> !wake_req_o);
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst_o || wake_req_o) |-> (post_cnt == '0));
  // R9: disabled watchdog is parked and silent
  a_r9_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en_i |=> (base_cnt == '0 && post_cnt == '0 && !wdt_rst_o && !wake_req_o));
endmodule

// File: tb/pm_watchdog_tb_top.sv
module pm_watchdog_tb_top;
  localparam time CLK_P  = 10ns;
  localparam int  BASE_W = 3;
  localparam int  SEL_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, wdt_en_i = 0, core_run_i = 1, kick_i = 0, sleep_i = 0;
  logic clk_lost_i = 0, fscm_en_i = 0, freq_wr_i = 0, int_osc_sel_i = 0;
  logic [SEL_W-1:0] ps_sel_i = '0;
  logic wdt_rst_o, wake_req_o, lfosc_en_o;

  int errors = 0;
  int checks = 0;
  int rst_seen = 0;
  int wake_seen = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pm_watchdog #(.BASE_W(BASE_W), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wdt_en_i(wdt_en_i),
    .core_run_i(core_run_i), .kick_i(kick_i), .sleep_i(sleep_i),
    .clk_lost_i(clk_lost_i), .fscm_en_i(fscm_en_i), .freq_wr_i(freq_wr_i),
    .int_osc_sel_i(int_osc_sel_i), .ps_sel_i(ps_sel_i),
    .wdt_rst_o(wdt_rst_o), .wake_req_o(wake_req_o), .lfosc_en_o(lfosc_en_o)
  );

  function automatic int period(input int n);
    return (1 << BASE_W) << n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock with optional tick; called and returns at a negedge
  task automatic step(input bit tk);
    tick_i = tk;
    @(negedge clk);
    tick_i = 0;
    rst_seen  += int'(wdt_rst_o);
    wake_seen += int'(wake_req_o);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  task automatic clear_counts();
    rst_seen = 0;
    wake_seen = 0;
  endtask

  task automatic restart();
    kick_i = 1;
    step(1'b0);
    kick_i = 0;
    step(1'b0);
    clear_counts();
  endtask

  task automatic t_reset_state();
    check("R1 reset rst", int'(wdt_rst_o), 0);
    check("R2 reset wake", int'(wake_req_o), 0);
    check("R10 lfosc off", int'(lfosc_en_o), 0);
  endtask

  task automatic t_run_timeout();
    core_run_i = 1; ps_sel_i = 0;
    restart();
    ticks(period(0) - 1);
    check("R1 no early request", rst_seen + wake_seen, 0);
    step(1'b1);
    check("R1 reset pulse", int'(wdt_rst_o), 1);
    check("R1 no wake", int'(wake_req_o), 0);
    step(1'b0);
    check("R3 reset one cycle", int'(wdt_rst_o), 0);
    clear_counts();
    ticks(period(0) - 1);
    check("R3 full period again", rst_seen, 0);
    step(1'b1);
    check("R3 second timeout", int'(wdt_rst_o), 1);
    step(1'b0);
  endtask

  task automatic t_idle_timeout();
    core_run_i = 0; ps_sel_i = 1;
    restart();
    ticks(period(1) - 1);
    check("R11 no wake before 2^(B+1)", rst_seen + wake_seen, 0);
    step(1'b1);
    check("R2 wake pulse", int'(wake_req_o), 1);
    check("R2 no reset", int'(wdt_rst_o), 0);
    step(1'b0);
    check("R3 wake one cycle", int'(wake_req_o), 0);
    core_run_i = 1;
  endtask

  task automatic t_large_sel();
    core_run_i = 1; ps_sel_i = 4;
    restart();
    ticks(period(4) - 1);
    check("R11 sel4 no early", rst_seen, 0);
    step(1'b1);
    check("R11 sel4 timeout", int'(wdt_rst_o), 1);
    step(1'b0);
    ps_sel_i = 0;
  endtask

  // src: 0 sleep, 1 kick, 2 clk loss, 3 freq write; qual enables the qualifier
  task automatic t_clear(input int src, input bit qual, input bit expect_clr, input string req);
    core_run_i = 1; ps_sel_i = 0;
    fscm_en_i = (src == 2) ? qual : 1'b0;
    int_osc_sel_i = (src == 3) ? qual : 1'b0;
    restart();
    ticks(period(0) - 2);
    sleep_i = (src == 0); kick_i = (src == 1);
    clk_lost_i = (src == 2); freq_wr_i = (src == 3);
    step(1'b0);
    sleep_i = 0; kick_i = 0; clk_lost_i = 0; freq_wr_i = 0;
    clear_counts();
    if (expect_clr) begin
      ticks(period(0) - 1);
      check(req, rst_seen, 0);
      step(1'b1);
      check(req, int'(wdt_rst_o), 1);
    end else begin
      ticks(2);
      check(req, int'(wdt_rst_o), 1);
    end
    step(1'b0);
    fscm_en_i = 0; int_osc_sel_i = 0;
  endtask

  task automatic t_clear_beats_tick();
    core_run_i = 1; ps_sel_i = 0;
    restart();
    ticks(period(0) - 1);
    kick_i = 1; sleep_i = 1;
    step(1'b1);
    kick_i = 0; sleep_i = 0;
    check("R8 no timeout on cleared tick", int'(wdt_rst_o), 0);
    clear_counts();
    ticks(period(0) - 1);
    check("R8 merged clear restarted count", rst_seen, 0);
    step(1'b1);
    check("R8 timeout after full period", int'(wdt_rst_o), 1);
    step(1'b0);
  endtask

  task automatic t_disable();
    core_run_i = 1; ps_sel_i = 0;
    restart();
    ticks(period(0) - 3);
    wdt_en_i = 0;
    clear_counts();
    ticks(3 * period(0));
    check("R9 silent while off", rst_seen + wake_seen, 0);
    check("R10 lfosc off", int'(lfosc_en_o), 0);
    fscm_en_i = 1;
    step(1'b0);
    check("R10 lfosc by monitor", int'(lfosc_en_o), 1);
    fscm_en_i = 0;
    wdt_en_i = 1;
    step(1'b0);
    check("R10 lfosc by watchdog", int'(lfosc_en_o), 1);
    clear_counts();
    ticks(period(0) - 1);
    check("R9 full period after enable", rst_seen, 0);
    step(1'b1);
    check("R9 timeout after enable", int'(wdt_rst_o), 1);
    step(1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    @(negedge clk);
    wdt_en_i = 1;
    @(negedge clk);
    t_run_timeout();
    t_idle_timeout();
    t_large_sel();
    t_clear(0, 1'b1, 1'b1, "R4 sleep clears");
    t_clear(1, 1'b1, 1'b1, "R5 kick clears");
    t_clear(2, 1'b1, 1'b1, "R6 loss clears with monitor");
    t_clear(2, 1'b0, 1'b0, "R6 loss ignored without monitor");
    t_clear(3, 1'b1, 1'b1, "R7 freq write clears on intosc");
    t_clear(3, 1'b0, 1'b0, "R7 freq write ignored off intosc");
    t_clear_beats_tick();
    t_disable();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule